// File: doc/BRIEF.md
# Escape Mode Lane Transmitter

This block drives the two single-ended low-power wires of one serial data lane during escape mode. It supports three kinds of escape: low-power data transfer, entry into and exit from the ultra-low-power state, and trigger commands. A rising edge on the escape request, qualified by a data, ultra-low-power or trigger selection, starts an entry pattern on the wire pair. An 8-bit command follows it, and then the phase that belongs to the selected operation.

Every symbol on the wires is held for `PHASE_CYC` system clock cycles. Each bit is sent as a one-hot mark followed by a space with both wires low, so the two wires never switch from one mark to the other. While data transfer is active, the lane accepts bytes through a valid/ready handshake and shifts each byte out least significant bit first. The ultra-low-power state lasts until an exit request arrives. After that request the lane drives a wake level for `WAKE_CYC` cycles and then returns to idle. The block reports when the lane is idle in stop state and, through an active-low flag, when it is in the ultra-low-power state.

Top module: `esc_lane_tx`

## Requirements
- R1: After reset and whenever idle the wire pair {lp_p,lp_n} is 2'b11, stop_state is 1, ulps_active_n is 1 and esc_ready is 0; stop_state is 1 exactly when the pair is 2'b11.
- R2: A rising edge of esc_req with at least one qualifier starts the entry pattern in the cycle after the sampling edge: 2'b10, 2'b00, 2'b01, 2'b00, each held PHASE_CYC cycles.
- R3: The command byte follows the entry pattern most significant bit first; each bit is a mark of PHASE_CYC cycles (2'b01 for 1, 2'b10 for 0) followed by a 2'b00 space of PHASE_CYC cycles.
- R4: The command is 8'hE1 for data, 8'h1E for ultra-low-power, and for trig_sel bits 0..3 8'h62, 8'h5D, 8'h21, 8'hA0; priority is data, then ultra-low-power, then the lowest set trig_sel bit.
- R5: After the data command the pair holds 2'b00. esc_valid with esc_req high is taken on one edge, and esc_ready is high for exactly the next cycle. The byte is then sent bit 0 first with the R3 mark/space coding, and the pair returns to 2'b00.
- R6: In data mode, esc_req low while no byte is in flight ends the escape: 2'b01 for PHASE_CYC cycles, then 2'b11 with stop_state high.
- R7: After a trigger command the lane at once sends 2'b01 for PHASE_CYC cycles and then returns to 2'b11.
- R8: After the ultra-low-power command the pair holds 2'b00 with ulps_active_n low for as long as ulps_exit is absent. ulps_exit then gives 2'b10 for WAKE_CYC cycles, with ulps_active_n still low, and after that 2'b11 with ulps_active_n high.
- R9: A request without a qualifier, a request held high after an escape has finished, and ulps_exit outside the ultra-low-power state leave the lane idle.
- R10: The pair never changes directly from 2'b10 to 2'b01 or from 2'b01 to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase timing counts it |
| rst_n | input | 1 | Active-low asynchronous reset |
| esc_req | input | 1 | Escape request; its rising edge starts an escape, and low ends data mode |
| esc_lpdt | input | 1 | Qualifier: low-power data transfer |
| esc_ulps | input | 1 | Qualifier: ultra-low-power state |
| trig_sel | input | 4 | Trigger selection: bit 0 reset, bit 1 test-mode entry, bits 2 and 3 the two unknown triggers |
| esc_valid | input | 1 | Data byte present |
| esc_data | input | 8 | Data byte, bit 0 sent first |
| esc_ready | output | 1 | One-cycle pulse: byte taken |
| ulps_exit | input | 1 | Request to leave the ultra-low-power state |
| lp_p | output | 1 | Positive low-power wire level |
| lp_n | output | 1 | Negative low-power wire level |
| stop_state | output | 1 | Lane idle in stop state |
| ulps_active_n | output | 1 | Low while in the ultra-low-power state |

## Verification
Every output is registered, so a change of input sampled on edge E shows on the outputs in the cycle after E. Phase j of an escape therefore covers cycles j·PHASE_CYC through j·PHASE_CYC+PHASE_CYC−1 after the start edge. The bench counts falling edges from the one at which it drives a stimulus and samples each phase at its middle, one falling edge later than the cycle index. It samples esc_ready on the first falling edge after the accepting edge and expects it low on the second. It checks the wake level on the second falling edge after ulps_exit is driven, and checks idle WAKE_CYC+1 falling edges after it.

// File: rtl/esc_lane_pkg.sv
package esc_lane_pkg;
    // wire pair symbols, named {p,n}
    typedef enum logic [1:0] {SYM_11, SYM_10, SYM_01, SYM_00} sym_t;
    typedef enum logic [2:0] {ST_IDLE, ST_ENTRY, ST_SER, ST_DATA, ST_ULPS, ST_WAKE, ST_EXIT} st_t;
    typedef enum logic [1:0] {MD_DATA, MD_ULPS, MD_TRIG} md_t;

    localparam logic [7:0] CMD_DATA = 8'hE1;
    localparam logic [7:0] CMD_ULPS = 8'h1E;
    localparam logic [7:0] CMD_TRST = 8'h62;
    localparam logic [7:0] CMD_TTST = 8'h5D;
    localparam logic [7:0] CMD_TUK4 = 8'h21;
    localparam logic [7:0] CMD_TUK5 = 8'hA0;

    function automatic sym_t mark_sym(input logic b);
        return b ? SYM_01 : SYM_10;
    endfunction
endpackage

// File: rtl/esc_cmd_sel.sv
module esc_cmd_sel
    import esc_lane_pkg::*;
(
    input  logic       sel_data,
    input  logic       sel_ulps,
    input  logic [3:0] sel_trig,
    output logic       hit,
    output md_t        mode,
    output logic [7:0] cmd
);
    always_comb begin
        hit  = 1'b1;
        mode = MD_TRIG;
        cmd  = 8'h00;
        if (sel_data) begin
            mode = MD_DATA;
            cmd  = CMD_DATA;
        end else if (sel_ulps) begin
            mode = MD_ULPS;
            cmd  = CMD_ULPS;
        end else if (sel_trig[0]) begin
            cmd = CMD_TRST;
        end else if (sel_trig[1]) begin
            cmd = CMD_TTST;
        end else if (sel_trig[2]) begin
            cmd = CMD_TUK4;
        end else if (sel_trig[3]) begin
            cmd = CMD_TUK5;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/esc_line_drv.sv
module esc_line_drv
    import esc_lane_pkg::*;
(
    input  sym_t sym,
    output logic p,
    output logic n
);
    always_comb begin
        unique case (sym)
            SYM_11:  {p, n} = 2'b11;
            SYM_10:  {p, n} = 2'b10;
            SYM_01:  {p, n} = 2'b01;
            default: {p, n} = 2'b00;
        endcase
    end
endmodule

// File: rtl/esc_lane_tx.sv
module esc_lane_tx
    import esc_lane_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int WAKE_CYC  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       esc_req,
    input  logic       esc_lpdt,
    input  logic       esc_ulps,
    input  logic [3:0] trig_sel,
    input  logic       esc_valid,
    input  logic [7:0] esc_data,
    output logic       esc_ready,
    input  logic       ulps_exit,
    output logic       lp_p,
    output logic       lp_n,
    output logic       stop_state,
    output logic       ulps_active_n
);
    localparam int MAXC = (PHASE_CYC > WAKE_CYC) ? PHASE_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PH_LD = CW'(PHASE_CYC - 1);
    localparam logic [CW-1:0] WK_LD = CW'(WAKE_CYC - 1);

    typedef struct packed {
        st_t        st;
        sym_t       sym;
        logic [CW-1:0] cnt;
        logic [2:0] step;
        logic       space;
        logic       is_cmd;
        md_t        md;
        logic [7:0] sh;
        logic       req;
        logic       rdy;
    } lane_t;

    lane_t q, d;
    logic  sel_hit;
    md_t   sel_md;
    logic [7:0] sel_cmd;
    logic  tick;

    esc_cmd_sel u_sel (
        .sel_data(esc_lpdt), .sel_ulps(esc_ulps), .sel_trig(trig_sel),
        .hit(sel_hit), .mode(sel_md), .cmd(sel_cmd)
    );

    esc_line_drv u_drv (.sym(q.sym), .p(lp_p), .n(lp_n));

    assign tick = (q.cnt == '0);

    always_comb begin
        d     = q;
        d.req = esc_req;
        d.rdy = 1'b0;
        if (!tick) d.cnt = q.cnt - 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (esc_req && !q.req && sel_hit) begin
                    d.st   = ST_ENTRY;
                    d.step = 3'd0;
                    d.sym  = SYM_10;
                    d.cnt  = PH_LD;
                    d.sh   = sel_cmd;
                    d.md   = sel_md;
                end
            end
            ST_ENTRY: begin
                if (tick) begin
                    d.cnt  = PH_LD;
                    d.step = q.step + 1'b1;
                    unique case (q.step)
                        3'd0:    d.sym = SYM_00;
                        3'd1:    d.sym = SYM_01;
                        3'd2:    d.sym = SYM_00;
                        default: begin
                            d.st     = ST_SER;
                            d.is_cmd = 1'b1;
                            d.step   = 3'd0;
                            d.space  = 1'b0;
                            d.sym    = mark_sym(q.sh[7]);
                        end
                    endcase
                end
            end
            ST_SER: begin
                if (tick) begin
                    d.cnt = PH_LD;
                    if (!q.space) begin
                        d.space = 1'b1;
                        d.sym   = SYM_00;
                    end else if (q.step == 3'd7) begin
                        if (!q.is_cmd || q.md == MD_DATA) begin
                            d.st  = ST_DATA;
                            d.sym = SYM_00;
                        end else if (q.md == MD_ULPS) begin
                            d.st  = ST_ULPS;
                            d.sym = SYM_00;
                        end else begin
                            d.st  = ST_EXIT;
                            d.sym = SYM_01;
                        end
                    end else begin
                        d.step  = q.step + 1'b1;
                        d.space = 1'b0;
                        if (q.is_cmd) begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.sym = mark_sym(q.sh[6]);
                        end else begin
                            d.sh  = {1'b0, q.sh[7:1]};
                            d.sym = mark_sym(q.sh[1]);
                        end
                    end
                end
            end
            ST_DATA: begin
                if (esc_req && esc_valid) begin
                    d.st     = ST_SER;
                    d.is_cmd = 1'b0;
                    d.step   = 3'd0;
                    d.space  = 1'b0;
                    d.sh     = esc_data;
                    d.sym    = mark_sym(esc_data[0]);
                    d.cnt    = PH_LD;
                    d.rdy    = 1'b1;
                end else if (!esc_req) begin
                    d.st  = ST_EXIT;
                    d.sym = SYM_01;
                    d.cnt = PH_LD;
                end
            end
            ST_ULPS: begin
                if (ulps_exit) begin
                    d.st  = ST_WAKE;
                    d.sym = SYM_10;
                    d.cnt = WK_LD;
                end
            end
            default: begin // ST_WAKE, ST_EXIT
                if (tick) begin
                    d.st  = ST_IDLE;
                    d.sym = SYM_11;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.sym    <= SYM_11;
            q.md     <= MD_DATA;
        end else begin
            q <= d;
        end
    end

    assign esc_ready     = q.rdy;
    assign stop_state    = (q.st == ST_IDLE);
    assign ulps_active_n = !(q.st == ST_ULPS || q.st == ST_WAKE);

    // R1: stop state coincides with the idle wire level
    a_r1_stop_lines: assert property (@(posedge clk) disable iff (!rst_n)
        stop_state == (lp_p && lp_n));
    // R5: ready is a single-cycle pulse
    a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        esc_ready |=> !esc_ready);
    // R5: ready only answers a presented byte
    a_r5_ready_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        esc_ready |-> $past(esc_valid));
    // R8: during ultra-low-power the negative wire stays low
    a_r8_ulps_n_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ulps_active_n |-> !lp_n);
    // R10: no direct swap between marks
    a_r10_no_swap_10: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_p && !lp_n) |=> !(!lp_p && lp_n));
    a_r10_no_swap_01: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_p && lp_n) |=> !(lp_p && !lp_n));
endmodule

// File: tb/esc_lane_tx_bench.sv
module esc_lane_tx_bench;
    localparam int P = 4;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic esc_req = 0, esc_lpdt = 0, esc_ulps = 0, esc_valid = 0, ulps_exit = 0;
    logic [3:0] trig_sel = 4'h0;
    logic [7:0] esc_data = 8'h00;
    logic esc_ready, lp_p, lp_n, stop_state, ulps_active_n;

    int n_chk = 0;
    int n_fail = 0;
    int rel = 0;

    always #10 clk = ~clk;

    esc_lane_tx #(.PHASE_CYC(P), .WAKE_CYC(W)) u_esc_lane_tx (
        .clk(clk), .rst_n(rst_n), .esc_req(esc_req), .esc_lpdt(esc_lpdt),
        .esc_ulps(esc_ulps), .trig_sel(trig_sel), .esc_valid(esc_valid),
        .esc_data(esc_data), .esc_ready(esc_ready), .ulps_exit(ulps_exit),
        .lp_p(lp_p), .lp_n(lp_n), .stop_state(stop_state),
        .ulps_active_n(ulps_active_n)
    );

    // {lpdt, ulps, trig[3:0], mode[1:0] (0 data,1 ulps,2 trig), cmd[7:0]}
    localparam logic [15:0] VEC [10] = '{
        {1'b1, 1'b0, 4'b0000, 2'd0, 8'hE1},
        {1'b0, 1'b1, 4'b0000, 2'd1, 8'h1E},
        {1'b0, 1'b0, 4'b0001, 2'd2, 8'h62},
        {1'b0, 1'b0, 4'b0010, 2'd2, 8'h5D},
        {1'b0, 1'b0, 4'b0100, 2'd2, 8'h21},
        {1'b0, 1'b0, 4'b1000, 2'd2, 8'hA0},
        {1'b1, 1'b1, 4'b0000, 2'd0, 8'hE1},
        {1'b0, 1'b1, 4'b0100, 2'd1, 8'h1E},
        {1'b0, 1'b0, 4'b0110, 2'd2, 8'h5D},
        {1'b0, 1'b0, 4'b1100, 2'd2, 8'h21}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic seek(input int c);
        while (rel < c) begin
            @(negedge clk);
            rel++;
        end
    endtask

    function automatic int mid(input int j);
        return j * P + P / 2 + 1;
    endfunction

    function automatic logic [7:0] pair();
        return {6'd0, lp_p, lp_n};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // decode 8 mark/space bits starting at phase j0; msb selects order
    task automatic grab(input int j0, input logic msb, input string req, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            seek(mid(j0 + 2 * i));
            if (msb) b[7 - i] = (pair() == 8'h01);
            else     b[i]     = (pair() == 8'h01);
            if (pair() != 8'h01 && pair() != 8'h02) chk(req, pair(), 8'h01);
            seek(mid(j0 + 2 * i + 1));
            chk(req, pair(), 8'h00);
        end
    endtask

    task automatic start(input logic dl, input logic ul, input logic [3:0] tg);
        @(negedge clk);
        esc_lpdt = dl; esc_ulps = ul; trig_sel = tg; esc_req = 1'b1;
        rel = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [7:0] got;
        esc_valid = 1'b1; esc_data = b; rel = 0;
        seek(1);
        chk("R5 ready pulse", {7'd0, esc_ready}, 8'h01);
        esc_valid = 1'b0;
        seek(2);
        chk("R5 ready one cycle", {7'd0, esc_ready}, 8'h00);
        grab(0, 1'b0, "R5 data bit", got);
        chk("R5 byte lsb first", got, b);
        seek(16 * P + 2);
        chk("R5 hold space", pair(), 8'h00);
    endtask

    initial begin
        logic [7:0] got;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 reset pair", pair(), 8'h03);
        chk("R1 reset stop", {7'd0, stop_state}, 8'h01);
        chk("R1 reset ulps_n", {7'd0, ulps_active_n}, 8'h01);
        chk("R1 reset ready", {7'd0, esc_ready}, 8'h00);

        foreach (VEC[k]) begin
            start(VEC[k][15], VEC[k][14], VEC[k][13:10]);
            seek(mid(0)); chk("R2 entry 10", pair(), 8'h02);
            seek(mid(1)); chk("R2 entry 00", pair(), 8'h00);
            seek(mid(2)); chk("R2 entry 01", pair(), 8'h01);
            seek(mid(3)); chk("R2 entry 00b", pair(), 8'h00);
            grab(4, 1'b1, "R3 command bit", got);
            chk("R4 command code", got, VEC[k][7:0]);
            seek(mid(20));
            if (VEC[k][9:8] == 2'd2) begin
                chk("R7 trigger exit mark", pair(), 8'h01);
                seek(mid(21));
                chk("R7 trigger idle", pair(), 8'h03);
                chk("R7 trigger stop", {7'd0, stop_state}, 8'h01);
                esc_req = 1'b0;
            end else if (VEC[k][9:8] == 2'd1) begin
                chk("R8 ulps space", pair(), 8'h00);
                chk("R8 ulps flag", {7'd0, ulps_active_n}, 8'h00);
                esc_req = 1'b0;
                wait_cyc(40);
                chk("R8 ulps held", pair(), 8'h00);
                ulps_exit = 1'b1; rel = 0;
                seek(2);
                chk("R8 wake level", pair(), 8'h02);
                chk("R8 flag during wake", {7'd0, ulps_active_n}, 8'h00);
                seek(W + 1);
                chk("R8 idle after wake", pair(), 8'h03);
                chk("R8 flag cleared", {7'd0, ulps_active_n}, 8'h01);
                ulps_exit = 1'b0;
            end else begin
                chk("R5 data hold space", pair(), 8'h00);
                chk("R5 not stop", {7'd0, stop_state}, 8'h00);
                esc_req = 1'b0; rel = 0;
                seek(2);
                chk("R6 exit mark", pair(), 8'h01);
                seek(P + 1);
                chk("R6 exit idle", pair(), 8'h03);
                chk("R6 exit stop", {7'd0, stop_state}, 8'h01);
            end
            esc_lpdt = 0; esc_ulps = 0; trig_sel = 4'h0;
            wait_cyc(3);
        end

        // R5/R6: two data bytes then exit
        start(1'b1, 1'b0, 4'h0);
        seek(mid(20));
        send_byte(8'hB4);
        send_byte(8'h4D);
        esc_req = 1'b0; rel = 0;
        seek(2);
        chk("R6 exit after data", pair(), 8'h01);
        seek(P + 1);
        chk("R6 idle after data", pair(), 8'h03);
        esc_lpdt = 1'b0;
        wait_cyc(3);

        // R9: request with no qualifier
        start(1'b0, 1'b0, 4'h0);
        wait_cyc(10);
        chk("R9 no qualifier pair", pair(), 8'h03);
        chk("R9 no qualifier stop", {7'd0, stop_state}, 8'h01);
        esc_req = 1'b0;
        wait_cyc(2);

        // R9: request held high after a trigger does not restart
        start(1'b0, 1'b0, 4'b0001);
        seek(mid(22));
        wait_cyc(30);
        chk("R9 held request idle", pair(), 8'h03);
        chk("R9 held request stop", {7'd0, stop_state}, 8'h01);
        esc_req = 1'b0; trig_sel = 4'h0;
        wait_cyc(2);

        // R9: exit request while idle
        ulps_exit = 1'b1;
        wait_cyc(5);
        chk("R9 exit ignored pair", pair(), 8'h03);
        chk("R9 exit ignored flag", {7'd0, ulps_active_n}, 8'h01);
        ulps_exit = 1'b0;
        wait_cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule